// File: doc/BRIEF.md
# Byte/Word Asynchronous ROM Read Sequencer

This block is a clocked host-side controller that reads an external asynchronous mask ROM. The ROM can be read one byte at a time or one 16-bit word at a time. A host hands over a byte address and a mode flag through a valid/ready handshake. The sequencer then drives the ROM chip-enable, output-enable, width select and address lines. It waits long enough to cover every access delay of the part, captures the data lines and returns the result with a one-cycle valid pulse.

All ROM delays are given as picosecond parameters next to the clock period. The sequencer turns each delay into a cycle count, rounding up. One ROM pin changes role with the mode. In byte mode it carries the least significant address bit, and the sequencer drives it. In word mode it carries data bit 15, and the sequencer releases and samples it. The sequencer makes sure the ROM and the host never drive that pin together.

After a read, chip-enable and output-enable stay asserted ("parked"), so the next read in the same mode only changes the address. A read in the other mode first releases the ROM outputs and waits out the output float time.

Top module: `rom_rd_seq`

## Requirements
- R1: After reset, req_ready is 1, rom_ce_n and rom_oe_n are 1, rom_lsb_oe is 0 and rsp_valid is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. While a read is in progress req_ready stays 0, and req_valid with another address has no effect on rom_addr or on the returned data.
- R3: req_addr is a byte address. rom_addr carries req_addr[21:1]. In byte mode (req_byte = 1) rom_word is 0, rom_lsb_oe is 1 and rom_lsb_out equals req_addr[0].
- R4: In byte mode the result is {8'h00, rom_d_in[7:0]}. Lines 8 and up are ignored. An address with bit 0 = 0 returns the low half of the stored word, and bit 0 = 1 returns the high half.
- R5: In word mode (req_byte = 0) rom_word is 1, rom_lsb_oe is 0 and the result is {rom_lsb_in, rom_d_in[14:0]}.
- R6: Data is captured ACC_CYC clock edges after the edge that last changed any ROM pin. ACC_CYC is the largest rounded-up access delay plus one cycle, which is 26 at the defaults. rsp_valid is a single-cycle pulse, 26 cycles after the accepting edge for a read with no mode change.
- R7: Two changes of the ROM address pins (rom_addr, rom_lsb_out) are at least ceil(T_RC/period) cycles apart, which is 25 at the defaults.
- R8: After a read, rom_ce_n and rom_oe_n stay 0. A following read in the same mode keeps them at 0 and has the R6 latency.
- R9: A read in the other mode from a parked bus first raises rom_ce_n and rom_oe_n for ceil(T_FLT/period) cycles (10 at the defaults) and only then drives the ROM pins. rom_lsb_oe never rises before output-enable has been high for that many cycles. Latency is 36 cycles at the defaults.
- R10: Capture happens only while rom_ce_n and rom_oe_n are both 0. rom_lsb_oe is never 1 while rom_word is 1 with the ROM outputs enabled.
- R11: In word mode req_addr[0] has no effect. Two byte addresses that differ only in bit 0 return the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ROM_AW+1 | Byte address of the read |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | One-cycle pulse, rsp_data valid |
| rsp_data | output | DW | Read result, upper byte zero in byte mode |
| rom_ce_n | output | 1 | ROM chip-enable, active low |
| rom_oe_n | output | 1 | ROM output-enable, active low |
| rom_word | output | 1 | ROM width select, 1 = 16-bit |
| rom_addr | output | ROM_AW | ROM address lines |
| rom_lsb_out | output | 1 | Value driven on the shared pin in byte mode |
| rom_lsb_oe | output | 1 | Drive enable for the shared pin |
| rom_d_in | input | DW-1 | ROM data lines 0 to 14 |
| rom_lsb_in | input | 1 | Sampled value of the shared pin (data bit 15) |

## Verification
The hardest case is the mode change from a parked word read to a byte read. During that change the ROM has just been driving the shared pin, and the sequencer must not drive it back until the float window has passed. The bench sets this up with a word read followed directly by a byte read. A behavioral ROM model in the bench returns garbage until its pins have been stable for the full access time. Bench monitors measure how long output-enable stays high before the shared-pin driver turns on, flag any cycle where both sides drive that pin, and measure the spacing of address changes.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT,
        ST_CAPT,
        ST_FLOAT
    } rrs_state_e;

    // delay in picoseconds -> whole clock cycles, rounded up
    function automatic int unsigned rrs_cycles(input int unsigned dly_ps,
                                               input int unsigned clk_ps);
        return (dly_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned rrs_max3(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rrs_down_ctr.sv
module rrs_down_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld) begin
            cnt_d = ld_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CTR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ld) && $past(cnt_q) == '0) |-> cnt_q == '0); // R6

endmodule

// File: rtl/rrs_lane_merge.sv
module rrs_lane_merge #(
    parameter int unsigned DW = 16
) (
    input  logic          wide,
    input  logic [DW-2:0] d_lo,
    input  logic          lsb_in,
    output logic [DW-1:0] word
);

    localparam int unsigned HALF = DW / 2;

    always_comb begin
        if (wide) begin
            word = {lsb_in, d_lo};
        end else begin
            word = {{(DW-HALF){1'b0}}, d_lo[HALF-1:0]};
        end
    end

endmodule

// File: rtl/rom_rd_seq.sv
module rom_rd_seq
    import rrs_pkg::*;
#(
    parameter int unsigned CLK_PS    = 4000,
    parameter int unsigned T_AA_PS   = 100000,
    parameter int unsigned T_ACE_PS  = 100000,
    parameter int unsigned T_OE_PS   = 50000,
    parameter int unsigned T_RC_PS   = 100000,
    parameter int unsigned T_FLT_PS  = 40000,
    parameter int unsigned ROM_AW    = 21,
    parameter int unsigned DW        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ROM_AW:0]   req_addr,
    input  logic              req_byte,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_word,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_lsb_out,
    output logic              rom_lsb_oe,
    input  logic [DW-2:0]     rom_d_in,
    input  logic              rom_lsb_in
);

    // ------------------------------------------------------------------
    // Derived timing, in cycles. ACC_CYC must be at least 3.
    // ------------------------------------------------------------------
    localparam int unsigned ACC_CYC = rrs_max3(rrs_cycles(T_AA_PS,  CLK_PS),
                                               rrs_cycles(T_ACE_PS, CLK_PS),
                                               rrs_cycles(T_OE_PS,  CLK_PS)) + 1;
    localparam int unsigned RC_CYC  = rrs_cycles(T_RC_PS, CLK_PS);
    localparam int unsigned FLT_RAW = rrs_cycles(T_FLT_PS, CLK_PS);
    localparam int unsigned FLT_CYC = (FLT_RAW == 0) ? 1 : FLT_RAW;
    localparam int unsigned CW      = $clog2(ACC_CYC + RC_CYC + FLT_CYC + 2);
    localparam int unsigned PINW    = ROM_AW + 5;

    typedef struct packed {
        rrs_state_e        st;
        logic              parked;
        logic [ROM_AW-1:0] pend_addr;
        logic              pend_lsb;
        logic              pend_byte;
        logic [ROM_AW-1:0] pin_addr;
        logic              pin_lsb;
        logic              pin_lsb_oe;
        logic              pin_ce_n;
        logic              pin_oe_n;
        logic              pin_word;
        logic              rsp_valid;
        logic [DW-1:0]     rsp_data;
    } seq_t;

    seq_t r_q, r_d;

    logic [CW-1:0] acc_cnt, rc_cnt, flt_cnt;
    logic          drive, flt_go;
    logic          guard_ok, accept;
    logic [DW-1:0] lane_word;

    logic [ROM_AW-1:0] src_addr;
    logic              src_lsb;
    logic              src_byte;

    // ------------------------------------------------------------------
    // Timing counters: access wait, address cycle guard, output float
    // ------------------------------------------------------------------
    rrs_down_ctr #(.W(CW)) u_acc_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (drive),
        .ld_val (CW'(ACC_CYC)),
        .cnt    (acc_cnt)
    );

    rrs_down_ctr #(.W(CW)) u_rc_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (drive),
        .ld_val (CW'(RC_CYC)),
        .cnt    (rc_cnt)
    );

    rrs_down_ctr #(.W(CW)) u_flt_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (flt_go),
        .ld_val (CW'(FLT_CYC)),
        .cnt    (flt_cnt)
    );

    rrs_lane_merge #(.DW(DW)) u_lane (
        .wide   (r_q.pin_word),
        .d_lo   (rom_d_in),
        .lsb_in (rom_lsb_in),
        .word   (lane_word)
    );

    assign guard_ok = (rc_cnt <= CW'(1));
    assign accept   = (r_q.st == ST_IDLE) && guard_ok && req_valid;

    // ------------------------------------------------------------------
    // Next-state logic
    // ------------------------------------------------------------------
    always_comb begin
        r_d       = r_q;
        r_d.rsp_valid = 1'b0;
        drive     = 1'b0;
        flt_go    = 1'b0;

        if (r_q.st == ST_IDLE) begin
            src_addr = req_addr[ROM_AW:1];
            src_lsb  = req_addr[0];
            src_byte = req_byte;
        end else begin
            src_addr = r_q.pend_addr;
            src_lsb  = r_q.pend_lsb;
            src_byte = r_q.pend_byte;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.pend_addr = req_addr[ROM_AW:1];
                    r_d.pend_lsb  = req_addr[0];
                    r_d.pend_byte = req_byte;
                    if (r_q.parked && (req_byte == r_q.pin_word)) begin
                        // width change: release ROM outputs first
                        flt_go         = 1'b1;
                        r_d.st         = ST_FLOAT;
                        r_d.parked     = 1'b0;
                        r_d.pin_ce_n   = 1'b1;
                        r_d.pin_oe_n   = 1'b1;
                        r_d.pin_lsb_oe = 1'b0;
                    end else begin
                        drive = 1'b1;
                    end
                end
            end
            ST_FLOAT: begin
                if (flt_cnt <= CW'(1)) begin
                    drive = 1'b1;
                end
            end
            ST_SETUP: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (acc_cnt <= CW'(2)) begin
                    r_d.st = ST_CAPT;
                end
            end
            ST_CAPT: begin
                r_d.rsp_valid = 1'b1;
                r_d.rsp_data  = lane_word;
                r_d.parked    = 1'b1;
                r_d.st        = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        if (drive) begin
            r_d.st         = ST_SETUP;
            r_d.pin_addr   = src_addr;
            r_d.pin_word   = !src_byte;
            r_d.pin_lsb    = src_byte ? src_lsb : 1'b0;
            r_d.pin_lsb_oe = src_byte;
            r_d.pin_ce_n   = 1'b0;
            r_d.pin_oe_n   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.st         <= ST_IDLE;
            r_q.pin_ce_n   <= 1'b1;
            r_q.pin_oe_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE) && guard_ok;
    assign rsp_valid   = r_q.rsp_valid;
    assign rsp_data    = r_q.rsp_data;
    assign rom_ce_n    = r_q.pin_ce_n;
    assign rom_oe_n    = r_q.pin_oe_n;
    assign rom_word    = r_q.pin_word;
    assign rom_addr    = r_q.pin_addr;
    assign rom_lsb_out = r_q.pin_lsb;
    assign rom_lsb_oe  = r_q.pin_lsb_oe;

    // ------------------------------------------------------------------
    // Checking: independent age counters on the ROM pins
    // ------------------------------------------------------------------
    logic [PINW-1:0] pins_now, pins_nxt;
    logic [CW-1:0]   pin_age_q, addr_age_q, quiet_q;

    assign pins_now = {r_q.pin_addr, r_q.pin_lsb, r_q.pin_lsb_oe,
                       r_q.pin_ce_n, r_q.pin_oe_n, r_q.pin_word};
    assign pins_nxt = {r_d.pin_addr, r_d.pin_lsb, r_d.pin_lsb_oe,
                       r_d.pin_ce_n, r_d.pin_oe_n, r_d.pin_word};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_age_q  <= CW'(ACC_CYC);
            addr_age_q <= CW'(RC_CYC);
            quiet_q    <= CW'(FLT_CYC);
        end else begin
            if (pins_nxt != pins_now)            pin_age_q <= '0;
            else if (pin_age_q < CW'(ACC_CYC))   pin_age_q <= pin_age_q + 1'b1;

            if ({r_d.pin_addr, r_d.pin_lsb} != {r_q.pin_addr, r_q.pin_lsb})
                addr_age_q <= '0;
            else if (addr_age_q < CW'(RC_CYC))
                addr_age_q <= addr_age_q + 1'b1;

            if (!rom_oe_n)                       quiet_q <= '0;
            else if (quiet_q < CW'(FLT_CYC))     quiet_q <= quiet_q + 1'b1;
        end
    end

    AST_ACCESS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(pin_age_q) >= CW'(ACC_CYC - 1)); // R6

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6

    AST_CYCLE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rom_addr, rom_lsb_out}) |-> $past(addr_age_q) >= CW'(RC_CYC - 1)); // R7

    AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_lsb_oe) |-> $past(quiet_q) >= CW'(FLT_CYC - 1)); // R9

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_word && !rom_ce_n && !rom_oe_n) |-> !rom_lsb_oe); // R10

    AST_CAPT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!rom_ce_n && !rom_oe_n)); // R10

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(rom_word)) |-> rsp_data[DW-1:DW/2] == '0); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && !$stable(rom_addr)) |-> !req_ready); // R2

endmodule

// File: tb/rom_rd_seq_bench.sv
module rom_rd_seq_bench;

    localparam int STABLE_MIN = 25;  // 100 ns / 4 ns
    localparam int LAT_PLAIN  = 26;
    localparam int LAT_SWITCH = 36;
    localparam int FLOAT_MIN  = 10;  // 40 ns / 4 ns
    localparam int RC_MIN     = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic        req_byte = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        rom_ce_n, rom_oe_n, rom_word;
    logic [20:0] rom_addr;
    logic        rom_lsb_out, rom_lsb_oe;
    logic [14:0] rom_d_in = '0;
    logic        rom_lsb_in = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rom_rd_seq u_rom_rd_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_byte(req_byte),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_word(rom_word),
        .rom_addr(rom_addr), .rom_lsb_out(rom_lsb_out), .rom_lsb_oe(rom_lsb_oe),
        .rom_d_in(rom_d_in), .rom_lsb_in(rom_lsb_in)
    );

    function automatic logic [15:0] romw(input logic [20:0] a);
        return a[15:0] ^ {a[20:16], a[20:10]} ^ 16'hC3A5;
    endfunction

    function automatic logic [15:0] exp_byte(input logic [21:0] ba);
        logic [15:0] w;
        w = romw(ba[21:1]);
        return {8'h00, ba[0] ? w[15:8] : w[7:0]};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural ROM and pin monitors ----------------
    logic [25:0] prev_pins = '1;
    int  stab    = 0;
    int  quiet   = 1000;
    int  gap     = 1000;
    logic prev_oe = 1'b0;
    logic [21:0] prev_a = '0;

    always @(negedge clk) begin
        logic [25:0] pins;
        logic [15:0] w;
        logic        sel;
        pins = {rom_addr, rom_lsb_out, rom_lsb_oe, rom_ce_n, rom_oe_n, rom_word};
        if (pins != prev_pins) stab = 0;
        else if (stab < 1000)  stab++;
        prev_pins = pins;
        w = romw(rom_addr);
        if (rom_ce_n || rom_oe_n || stab < STABLE_MIN) begin
            rom_d_in   = 15'h2AAA;
            rom_lsb_in = 1'b1;
        end else if (rom_word) begin
            rom_d_in   = w[14:0];
            rom_lsb_in = w[15];
        end else begin
            sel        = rom_lsb_oe ? rom_lsb_out : 1'b1;
            rom_d_in   = {7'h55, sel ? w[15:8] : w[7:0]};
            rom_lsb_in = rom_lsb_out;
        end

        if (rst_n) begin
            if (rom_word && !rom_ce_n && !rom_oe_n && rom_lsb_oe)
                check(1'b0, "R10 shared pin contention", 32'(rom_lsb_oe), 32'h0);
            if (rom_lsb_oe && !prev_oe)
                check(quiet >= FLOAT_MIN, "R9 float gap before drive", quiet, FLOAT_MIN);
            if ({rom_addr, rom_lsb_out} != prev_a) begin
                if (gap < 1000)
                    check(gap + 1 >= RC_MIN, "R7 address spacing", gap + 1, RC_MIN);
                gap = 0;
            end else if (gap < 1000) gap++;
        end
        prev_oe = rom_lsb_oe;
        prev_a  = {rom_addr, rom_lsb_out};
        if (!rom_oe_n) quiet = 0;
        else if (quiet < 1000) quiet++;
    end

    // ---------------- request driver ----------------
    task automatic do_read(input logic [21:0] a, input logic bm,
                           output logic [15:0] d, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_byte = bm;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        d = rsp_data;
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        check(rom_ce_n && rom_oe_n, "R1 ce/oe idle", {rom_ce_n, rom_oe_n}, 32'h3);
        check(rom_lsb_oe == 1'b0, "R1 shared pin released", 32'(rom_lsb_oe), 0);
        check(rsp_valid == 1'b0, "R1 no response", 32'(rsp_valid), 0);
    endtask

    task automatic t_byte;
        logic [15:0] d; int lat;
        do_read(22'h12345, 1'b1, d, lat);
        check(lat == LAT_PLAIN, "R6 byte latency", lat, LAT_PLAIN);
        check(d == exp_byte(22'h12345), "R4 byte high half", d, exp_byte(22'h12345));
        check(rom_addr == 21'(22'h12345 >> 1) && rom_lsb_out && rom_lsb_oe && !rom_word,
              "R3 byte pins", {rom_addr, rom_lsb_out, rom_lsb_oe, rom_word},
              {21'(22'h12345 >> 1), 3'b110});
        @(negedge clk);
        check(rsp_valid == 1'b0, "R6 single pulse", 32'(rsp_valid), 0);
    endtask

    task automatic t_back_to_back;
        logic [15:0] d; int lat;
        check(!rom_ce_n && !rom_oe_n, "R8 parked after read", {rom_ce_n, rom_oe_n}, 0);
        do_read(22'h0ABCC, 1'b1, d, lat);
        check(lat == LAT_PLAIN, "R8 same-mode latency", lat, LAT_PLAIN);
        check(d == exp_byte(22'h0ABCC), "R4 byte low half", d, exp_byte(22'h0ABCC));
        do_read(22'h3FFFFF, 1'b1, d, lat);
        check(d == exp_byte(22'h3FFFFF), "R4 top byte address", d, exp_byte(22'h3FFFFF));
    endtask

    task automatic t_word;
        logic [15:0] d, d2; int lat;
        do_read(22'h2468A, 1'b0, d, lat);
        check(lat == LAT_SWITCH, "R9 byte-to-word latency", lat, LAT_SWITCH);
        check(d == romw(21'h12345), "R5 word data", d, romw(21'h12345));
        check(rom_word && !rom_lsb_oe, "R5 word pins", {rom_word, rom_lsb_oe}, 32'h2);
        do_read(22'h2468B, 1'b0, d2, lat);
        check(d2 == d, "R11 bit0 ignored in word mode", d2, d);
        check(lat == LAT_PLAIN, "R8 word same-mode latency", lat, LAT_PLAIN);
    endtask

    task automatic t_switch_back;
        logic [15:0] d; int lat;
        do_read(22'h00001, 1'b1, d, lat);
        check(lat == LAT_SWITCH, "R9 word-to-byte latency", lat, LAT_SWITCH);
        check(d == exp_byte(22'h00001), "R4 byte after switch", d, exp_byte(22'h00001));
    endtask

    task automatic t_busy;
        bit stayed_low = 1'b1;
        bit addr_held  = 1'b1;
        logic [15:0] d;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 22'h1F0F0; req_byte = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            req_addr = 22'h00F0F;
            if (req_ready) stayed_low = 1'b0;
            if (rom_addr != 21'(22'h1F0F0 >> 1)) addr_held = 1'b0;
        end
        req_valid = 1'b0;
        check(stayed_low, "R2 ready low while busy", 32'(stayed_low), 1);
        check(addr_held, "R2 address held while busy", 32'(addr_held), 1);
        while (!rsp_valid) @(negedge clk);
        d = rsp_data;
        check(d == exp_byte(22'h1F0F0), "R2 data of accepted request", d, exp_byte(22'h1F0F0));
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte();
        t_back_to_back();
        t_word();
        t_switch_back();
        t_busy();
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule